// File: doc/BRIEF.md
# Mode-banked register file

This block holds the general-purpose registers of a 32-bit processor core whose register storage depends on the processor mode. Sixteen logical indices are visible at any time. A 5-bit mode input decides which physical copy each index reaches. The low indices and the program counter index are common to every mode. The fast-interrupt mode has a private copy of indices 8 to 14. The four other exception modes each have a private stack pointer (index 13) and link register (index 14).

The block has two combinational read ports and one write port that follow the active mode. A second write port takes its own mode operand, so that the exception-entry sequencer can load the link register of the mode it is about to enter before the mode input changes. Each exception mode also owns one saved status word. That word has a read port that follows the active mode and a write port that takes its own mode operand. In the unbanked modes, the saved-status read returns the live status word supplied on an input instead.

Top module: `bank_regfile`

## Requirements
- R1: Both read ports return, in the same cycle and without a clock, the 32-bit content of the physical register selected by the index and `mode_i`. A write takes effect at the next rising clock edge, so a read of a register being written in the same cycle returns the old value.
- R2: Indices 0 to 7 and index 15 reach one shared physical register each, whatever the mode.
- R3: In fast-interrupt mode (encoding 5'b10001), indices 8 to 14 reach seven registers private to that mode.
- R4: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private registers for indices 13 and 14. Their indices 8 to 12 reach the same registers as user mode.
- R5: User mode (5'b10000) and system mode (5'b11111) reach the same registers. Any encoding not listed in R3, R4 or R5 is treated as user mode.
- R6: The explicit write port stores into the register that its own mode and index select, whatever `mode_i` is. When both write ports hit the same physical register in one cycle, the explicit port's data is kept. When they hit different registers, both writes land.
- R7: Each of the five exception modes owns a saved status word. `ss_rd_data` returns the word of the active mode. A write with `ss_wr_mode` naming an exception mode stores into that mode's word at the next clock edge.
- R8: In user, system or unrecognised modes, `ss_rd_data` equals `cur_status_i`. A saved-status write whose `ss_wr_mode` is one of those modes changes no stored word.
- R9: Reset (active-low `rst_n`) clears all five saved status words to zero and leaves the general registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Active processor mode |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable, active-mode write port |
| wr_idx | input | 4 | Logical index, active-mode write port |
| wr_data | input | 32 | Write data, active-mode write port |
| xwr_en | input | 1 | Write enable, explicit-mode write port |
| xwr_mode | input | 5 | Target mode, explicit-mode write port |
| xwr_idx | input | 4 | Logical index, explicit-mode write port |
| xwr_data | input | 32 | Write data, explicit-mode write port |
| cur_status_i | input | 32 | Live status word, returned in unbanked modes |
| ss_rd_data | output | 32 | Saved status word of the active mode |
| ss_wr_en | input | 1 | Saved status write enable |
| ss_wr_mode | input | 5 | Mode whose saved status word is written |
| ss_wr_data | input | 32 | Saved status write data |

## Verification
The bench loads every index of every mode through the explicit port with a value that encodes the mode and the index. It then reads every index in every mode, including one unrecognised encoding, on both ports. This catches a map that shares too much, which would let a later mode's value overwrite an earlier one, and a map that shares too little, which would make shared indices disagree between modes. It writes into the same physical register from both ports in one cycle. A wrong priority would keep the active-mode data, and a port that blocks the other would lose the second write. It also reads a register while it is being written: a design with a bypass would show the new value one cycle early. Finally, it writes and reads the saved status word in every mode, so a design that stores user-mode writes, or that returns a stored word instead of the live status in unbanked modes, produces a mismatch.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

    typedef enum logic [4:0] {
        MODE_USER  = 5'b10000,
        MODE_FAST  = 5'b10001,
        MODE_IRQ   = 5'b10010,
        MODE_SUPER = 5'b10011,
        MODE_ABORT = 5'b10111,
        MODE_UNDEF = 5'b11011,
        MODE_SYS   = 5'b11111
    } mode_e;

    // Register bank a mode selects; BANK_BASE covers user, system and unknown codes.
    typedef enum logic [2:0] {
        BANK_BASE  = 3'd0,
        BANK_FAST  = 3'd1,
        BANK_IRQ   = 3'd2,
        BANK_SUPER = 3'd3,
        BANK_ABORT = 3'd4,
        BANK_UNDEF = 3'd5
    } bank_e;

    localparam int NUM_LOG       = 16;
    localparam int FAST_LO       = 8;
    localparam int FAST_HI       = 14;
    localparam int PAIR_LO       = 13;
    localparam int FAST_COUNT    = FAST_HI - FAST_LO + 1;
    localparam int PAIR_COUNT    = 2;
    localparam int PAIR_MODES    = 4;
    localparam int FAST_BASE     = NUM_LOG;
    localparam int PAIR_BASE     = FAST_BASE + FAST_COUNT;
    localparam int NUM_PHYS      = PAIR_BASE + PAIR_COUNT * PAIR_MODES;
    localparam int NUM_SAVED     = 1 + PAIR_MODES;

    function automatic bank_e decode_bank(input logic [4:0] m);
        bank_e b;
        case (m)
            MODE_FAST:  b = BANK_FAST;
            MODE_IRQ:   b = BANK_IRQ;
            MODE_SUPER: b = BANK_SUPER;
            MODE_ABORT: b = BANK_ABORT;
            MODE_UNDEF: b = BANK_UNDEF;
            default:    b = BANK_BASE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import bank_regfile_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PIDX_W = 5
) (
    input  logic [4:0]        mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [PIDX_W-1:0] pidx
);

    bank_e bank;
    int    phys;

    always_comb begin
        bank = decode_bank(mode);
        phys = int'(idx);
        unique case (bank)
            BANK_FAST: begin
                if (int'(idx) >= FAST_LO && int'(idx) <= FAST_HI)
                    phys = FAST_BASE + int'(idx) - FAST_LO;
            end
            BANK_IRQ, BANK_SUPER, BANK_ABORT, BANK_UNDEF: begin
                if (int'(idx) >= PAIR_LO && int'(idx) < PAIR_LO + PAIR_COUNT)
                    phys = PAIR_BASE + PAIR_COUNT * (int'(bank) - int'(BANK_IRQ))
                           + int'(idx) - PAIR_LO;
            end
            BANK_BASE: phys = int'(idx);
        endcase
        pidx = PIDX_W'(phys);
    end

endmodule

// File: rtl/gp_store.sv
module gp_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_q,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_q,
    input  logic              wa_en,
    input  logic [AW-1:0]     wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [AW-1:0]     wb_addr,
    input  logic [DATA_W-1:0] wb_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    // No reset: general registers hold their value through reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wb_en && int'(wb_addr) == g)
                cells[g] <= wb_data;
            else if (wa_en && int'(wa_addr) == g)
                cells[g] <= wa_data;
        end
    end

    always_comb begin
        rd_a_q = '0;
        rd_b_q = '0;
        if (int'(rd_a_addr) < DEPTH) rd_a_q = cells[rd_a_addr];
        if (int'(rd_b_addr) < DEPTH) rd_b_q = cells[rd_b_addr];
    end

endmodule

// File: rtl/saved_store.sv
module saved_store
    import bank_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             rd_bank,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  bank_e             wr_bank,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [NUM_SAVED];

    for (genvar s = 0; s < NUM_SAVED; s++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[s] <= '0;
            else if (wr_en && wr_bank != BANK_BASE && int'(wr_bank) - 1 == s)
                words[s] <= wr_data;
        end
    end

    always_comb begin
        rd_q = '0;
        if (rd_bank != BANK_BASE)
            rd_q = words[int'(rd_bank) - 1];
    end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xwr_en,
    input  logic [4:0]        xwr_mode,
    input  logic [IDX_W-1:0]  xwr_idx,
    input  logic [DATA_W-1:0] xwr_data,
    input  logic [DATA_W-1:0] cur_status_i,
    output logic [DATA_W-1:0] ss_rd_data,
    input  logic              ss_wr_en,
    input  logic [4:0]        ss_wr_mode,
    input  logic [DATA_W-1:0] ss_wr_data
);

    localparam int PIDX_W = $clog2(NUM_PHYS);

    logic [PIDX_W-1:0] pa, pb, pw, px;
    logic [DATA_W-1:0] saved_q;
    bank_e             act_bank;

    bank_map #(.IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_a (.mode(mode_i),   .idx(rd_a_idx), .pidx(pa));
    bank_map #(.IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_b (.mode(mode_i),   .idx(rd_b_idx), .pidx(pb));
    bank_map #(.IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_w (.mode(mode_i),   .idx(wr_idx),   .pidx(pw));
    bank_map #(.IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_x (.mode(xwr_mode), .idx(xwr_idx),  .pidx(px));

    gp_store #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .AW(PIDX_W)) u_store (
        .clk       (clk),
        .rd_a_addr (pa),
        .rd_a_q    (rd_a_data),
        .rd_b_addr (pb),
        .rd_b_q    (rd_b_data),
        .wa_en     (wr_en),
        .wa_addr   (pw),
        .wa_data   (wr_data),
        .wb_en     (xwr_en),
        .wb_addr   (px),
        .wb_data   (xwr_data)
    );

    assign act_bank = decode_bank(mode_i);

    saved_store #(.DATA_W(DATA_W)) u_saved (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_bank (act_bank),
        .rd_q    (saved_q),
        .wr_en   (ss_wr_en),
        .wr_bank (decode_bank(ss_wr_mode)),
        .wr_data (ss_wr_data)
    );

    assign ss_rd_data = (act_bank == BANK_BASE) ? cur_status_i : saved_q;

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              xwr_en,
    input logic [4:0]        xwr_mode,
    input logic [IDX_W-1:0]  xwr_idx,
    input logic [DATA_W-1:0] xwr_data,
    input logic [DATA_W-1:0] cur_status_i,
    input logic [DATA_W-1:0] ss_rd_data,
    input logic              ss_wr_en,
    input logic [4:0]        ss_wr_mode,
    input logic [DATA_W-1:0] ss_wr_data
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic is_banked(input logic [4:0] m);
        return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
               (m == 5'b10111) || (m == 5'b11011);
    endfunction

    assert_wr_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !xwr_en) |=>
        ((mode_i == $past(mode_i) && rd_a_idx == $past(wr_idx)) ? (rd_a_data == $past(wr_data)) : 1'b1));

    assert_shared_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_en) && !$past(xwr_en) && rd_a_idx == $past(rd_a_idx) &&
         (rd_a_idx < 4'd8 || rd_a_idx == 4'd15)) |-> (rd_a_data == $past(rd_a_data)));

    assert_xwr_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xwr_en |=>
        ((mode_i == $past(xwr_mode) && rd_a_idx == $past(xwr_idx)) ? (rd_a_data == $past(xwr_data)) : 1'b1));

    assert_saved_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_wr_en && is_banked(ss_wr_mode)) |=>
        ((mode_i == $past(ss_wr_mode)) ? (ss_rd_data == $past(ss_wr_data)) : 1'b1));

    assert_live_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_banked(mode_i) |-> (ss_rd_data == cur_status_i));

endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .xwr_en       (xwr_en),
    .xwr_mode     (xwr_mode),
    .xwr_idx      (xwr_idx),
    .xwr_data     (xwr_data),
    .cur_status_i (cur_status_i),
    .ss_rd_data   (ss_rd_data),
    .ss_wr_en     (ss_wr_en),
    .ss_wr_mode   (ss_wr_mode),
    .ss_wr_data   (ss_wr_data)
);

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  mode_i;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, xwr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, xwr_data;
    logic        wr_en, xwr_en, ss_wr_en;
    logic [4:0]  xwr_mode, ss_wr_mode;
    logic [31:0] cur_status_i, ss_rd_data, ss_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] mdl [31];
    logic [31:0] smdl [5];
    logic [4:0]  modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                               5'b10111, 5'b11011, 5'b11111, 5'b00000};

    always #2 clk = ~clk;

    bank_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .xwr_en(xwr_en), .xwr_mode(xwr_mode), .xwr_idx(xwr_idx), .xwr_data(xwr_data),
        .cur_status_i(cur_status_i), .ss_rd_data(ss_rd_data),
        .ss_wr_en(ss_wr_en), .ss_wr_mode(ss_wr_mode), .ss_wr_data(ss_wr_data)
    );

    // Saved-status slot from R7; -1 for user, system and unknown (R8).
    function automatic int slot_of(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    // Physical slot numbering of the bench's own model, from R2..R5.
    function automatic int phys_of(input logic [4:0] m, input int i);
        int s;
        s = slot_of(m);
        if (s == 0 && i >= 8 && i <= 14) return 16 + i - 8;
        if (s > 0 && (i == 13 || i == 14)) return 23 + 2 * (s - 1) + i - 13;
        return i;
    endfunction

    function automatic string tag_of(input logic [4:0] m, input int i);
        if (i < 8 || i == 15) return "R2";
        if (slot_of(m) == 0)  return "R3";
        if (slot_of(m) > 0)   return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xwrite(input logic [4:0] m, input int i, input logic [31:0] d);
        @(negedge clk);
        xwr_en = 1'b1; xwr_mode = m; xwr_idx = 4'(i); xwr_data = d;
        @(negedge clk);
        xwr_en = 1'b0;
        mdl[phys_of(m, i)] = d;
    endtask

    task automatic awrite(input logic [4:0] m, input int i, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[phys_of(m, i)] = d;
    endtask

    task automatic sweep();
        for (int mi = 0; mi < 8; mi++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                mode_i = modes[mi]; rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
                #1;
                chk(tag_of(modes[mi], i), rd_a_data, mdl[phys_of(modes[mi], i)]);
                chk(tag_of(modes[mi], 15 - i), rd_b_data, mdl[phys_of(modes[mi], 15 - i)]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_i = 5'b10000; rd_a_idx = '0; rd_b_idx = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        xwr_en = 1'b0; xwr_mode = 5'b10000; xwr_idx = '0; xwr_data = '0;
        ss_wr_en = 1'b0; ss_wr_mode = 5'b10000; ss_wr_data = '0;
        cur_status_i = 32'h1234_5678;
        for (int s = 0; s < 5; s++) smdl[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: saved words cleared by reset
        for (int mi = 1; mi < 6; mi++) begin
            @(negedge clk); mode_i = modes[mi]; #1;
            chk("R9", ss_rd_data, 32'h0);
        end
        // R8: live status in user mode
        @(negedge clk); mode_i = 5'b10000; #1;
        chk("R8", ss_rd_data, 32'h1234_5678);

        // R6: load every index of every mode through the explicit port
        for (int mi = 0; mi < 8; mi++)
            for (int i = 0; i < 16; i++)
                xwrite(modes[mi], i, 32'hA500_0000 | (mi << 8) | i);
        sweep();

        // Active-mode writes to banked indices in every mode
        for (int mi = 0; mi < 8; mi++) begin
            for (int i = 8; i < 15; i++) awrite(modes[mi], i, 32'h5A00_0000 | (mi << 8) | i);
            awrite(modes[mi], 0, 32'h5A00_0000 | (mi << 8));
        end
        sweep();

        // R1: no bypass, old value during the write cycle
        @(negedge clk);
        mode_i = 5'b10000; wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'hBEEF_0002; rd_a_idx = 4'd2;
        #1 chk("R1", rd_a_data, mdl[2]);
        @(negedge clk); wr_en = 1'b0; mdl[2] = 32'hBEEF_0002; #1;
        chk("R1", rd_a_data, 32'hBEEF_0002);

        // R6: both ports hit the same shared register
        @(negedge clk);
        mode_i = 5'b10000; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1111_0003;
        xwr_en = 1'b1; xwr_mode = 5'b10010; xwr_idx = 4'd3; xwr_data = 32'h2222_0003;
        @(negedge clk); wr_en = 1'b0; xwr_en = 1'b0; rd_a_idx = 4'd3; #1;
        chk("R6", rd_a_data, 32'h2222_0003);
        mdl[3] = 32'h2222_0003;

        // R6: same index, different physical registers
        @(negedge clk);
        mode_i = 5'b10000; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h3333_000D;
        xwr_en = 1'b1; xwr_mode = 5'b10010; xwr_idx = 4'd13; xwr_data = 32'h4444_000D;
        @(negedge clk); wr_en = 1'b0; xwr_en = 1'b0; rd_a_idx = 4'd13; #1;
        chk("R6", rd_a_data, 32'h3333_000D);
        @(negedge clk); mode_i = 5'b10010; #1;
        chk("R6", rd_a_data, 32'h4444_000D);
        mdl[13] = 32'h3333_000D; mdl[phys_of(5'b10010, 13)] = 32'h4444_000D;

        // R7/R8: saved status writes in every mode, with active mode held at user
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode_i = 5'b10000; ss_wr_en = 1'b1; ss_wr_mode = modes[mi];
            ss_wr_data = 32'hC000_0000 | mi;
            @(negedge clk); ss_wr_en = 1'b0;
            if (slot_of(modes[mi]) >= 0) smdl[slot_of(modes[mi])] = 32'hC000_0000 | mi;
        end
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode_i = modes[mi]; cur_status_i = 32'hDEAD_0000 | mi; #1;
            if (slot_of(modes[mi]) >= 0) chk("R7", ss_rd_data, smdl[slot_of(modes[mi])]);
            else                         chk("R8", ss_rd_data, 32'hDEAD_0000 | mi);
        end

        sweep();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end

endmodule